// File: doc/BRIEF.md
# Saturating Branch Sample Buffer

This block records the source and target addresses of consecutive taken branches into a small file of entry pairs. One configuration word governs it. That word holds a recording enable, a flag that shows at least one branch has been captured, the index of the next entry to fill, and a selector that names one of several performance counters. Recording makes a single pass through the entries. When the last entry is filled, the block clears its own enable and stops recording. It does not wrap around and overwrite older data.

Software reads and writes the entries and the configuration word through a simple register port. Each entry has two words: the source address sits at an even offset and the target address at the odd offset just above it. The configuration word sits directly above the last entry. Software can write a marker into any target word to flag that entry as stale. An overflow from the selected counter is held back while recording runs. It is released as a one-cycle interrupt pulse once the enable is low, whether the block or software cleared it. That way the interrupt arrives with a complete set of samples.

Top module: `branch_sample_buf`

## Requirements
- R1: After reset the configuration word reads 0x18, every entry word reads 0, and the interrupt is low.
- R2: In the configuration word, bit 2 is the enable, bit 5 the valid flag, bits 19:16 the next-write index and bits 26:24 the counter select. Bits 4:3 always read 1 whatever is written, and all other bits read 0.
- R3: While enabled, a taken-branch strobe stores the source address at word 2*i and the target at word 2*i+1 of entry i, where i is the next-write index. The index then advances by one and the valid flag is set.
- R4: While the enable is 0, a taken-branch strobe changes neither the entries nor the index.
- R5: Filling the last entry (index 15) clears the enable and returns the index to 0. Later strobes leave entry 0 unchanged.
- R6: An overflow of the selected counter that arrives while enabled gives no interrupt during recording. Once the block clears the enable, the interrupt pulses high for exactly one cycle, on the second clock edge after the edge that filled the last entry.
- R7: A software write that clears the enable releases a held overflow: the interrupt pulses on the second clock edge after the write edge.
- R8: An overflow on a counter other than the selected one produces no interrupt.
- R9: An overflow of the selected counter while disabled pulses the interrupt on the second clock edge after the overflow edge.
- R10: Addresses are kept as 48 bits and read back sign-extended from bit 47 to 64 bits.
- R11: Software writes to an entry word take effect. A target written with 0xFFFF_FFFF_FFFF_FFFE reads back as that same value.
- R12: A configuration write in the same cycle as a taken-branch strobe wins, and that branch is not recorded.
- R13: The valid flag stays set until software writes the configuration word with bit 5 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brValid | input | 1 | Taken-branch strobe, one per branch |
| brFrom | input | 48 | Branch source address |
| brTo | input | 48 | Branch target address |
| ovfIn | input | 8 | Counter overflow triggers, one per counter |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Word address: entries 0..31, configuration at 32 |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Read data for regAddr, combinational |
| irqOut | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The bench feeds a full pass of sixteen branches. Even and odd entries alternate the sign of the address bit 47, in opposite phase for source and target. This separates correct sign extension from a plain zero extension, and it catches source and target being swapped. Strobes sent while disabled, after saturation, and in the same cycle as a configuration write show whether recording is gated by the enable, stops at the end of the pass, and yields to software. Overflow pulses are sent on the selected counter and on a foreign counter, both with recording active and idle. The interrupt is sampled cycle by cycle, which separates holding the interrupt from dropping it or releasing it early.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
  // bit positions inside the configuration word
  localparam int EN_BIT  = 2;
  localparam int FIX_LSB = 3;
  localparam int VB_BIT  = 5;
  localparam int IDX_LSB = 16;
  localparam int SEL_LSB = 24;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic swWrFrom;
    logic swWrTo;
  } bsbStrobe_t;
endpackage

// File: rtl/bsb_ctrl.sv
module bsb_ctrl
  import bsb_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NUM_CNT = 8,
  parameter int DATA_W  = 64,
  parameter int RA_W    = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       brValid,
  input  logic [NUM_CNT-1:0]         ovfIn,
  input  logic                       regWrEn,
  input  logic [RA_W-1:0]            regAddr,
  input  logic [DATA_W-1:0]          regWrData,
  output bsbStrobe_t                 strobe,
  output logic [$clog2(DEPTH)-1:0]   capIdx,
  output logic [$clog2(DEPTH)-1:0]   swIdx,
  output logic                       cfgSel,
  output logic [DATA_W-1:0]          cfgRdData,
  output logic                       irqOut
);
  localparam int IDX_W    = $clog2(DEPTH);
  localparam int SEL_W    = $clog2(NUM_CNT);
  localparam int CFG_ADDR = 2 * DEPTH;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic             enQ, vbQ, pendQ, irqQ;
  logic [IDX_W-1:0] idxQ;
  logic [SEL_W-1:0] selQ;
  logic             cfgHit, entryHit, ovfHit;

  assign cfgSel   = (regAddr == RA_W'(CFG_ADDR));
  assign cfgHit   = regWrEn && cfgSel;
  assign entryHit = regWrEn && (regAddr < RA_W'(CFG_ADDR));
  assign ovfHit   = ovfIn[selQ];

  assign swIdx           = regAddr[IDX_W:1];
  assign capIdx          = idxQ;
  assign strobe.capture  = brValid && enQ && !cfgHit;
  assign strobe.swWrFrom = entryHit && !regAddr[0];
  assign strobe.swWrTo   = entryHit && regAddr[0];

  // configuration state: software write has priority over capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= 1'b0;
      vbQ  <= 1'b0;
      idxQ <= '0;
      selQ <= '0;
    end else if (cfgHit) begin
      enQ  <= regWrData[EN_BIT];
      vbQ  <= regWrData[VB_BIT];
      idxQ <= regWrData[IDX_LSB +: IDX_W];
      selQ <= regWrData[SEL_LSB +: SEL_W];
    end else if (strobe.capture) begin
      vbQ <= 1'b1;
      if (idxQ == LAST_IDX) begin
        idxQ <= '0;
        enQ  <= 1'b0;
      end else begin
        idxQ <= idxQ + 1'b1;
      end
    end
  end

  // overflow hold: pending while recording, released once enable is low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      irqQ  <= pendQ && !enQ;
      pendQ <= ovfHit || (pendQ && enQ);
    end
  end
  assign irqOut = irqQ;

  always_comb begin
    cfgRdData = '0;
    cfgRdData[EN_BIT]               = enQ;
    cfgRdData[FIX_LSB +: 2]         = 2'b11;
    cfgRdData[VB_BIT]               = vbQ;
    cfgRdData[IDX_LSB +: IDX_W]     = idxQ;
    cfgRdData[SEL_LSB +: SEL_W]     = selQ;
  end

  // R5: capture into the last entry ends the pass
  a_r5_full_stops: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && idxQ == LAST_IDX |=> !enQ && idxQ == '0);
  // R4: idle index does not move without a software write
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !enQ && !cfgHit |=> $stable(idxQ));
  // R6: no interrupt is emitted while recording was active
  a_r6_irq_held: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(!enQ));
  // R3: a capture leaves the valid flag set
  a_r3_vb_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> vbQ);
  // R13: valid flag is sticky until a configuration write
  a_r13_vb_sticky: assert property (@(posedge clk) disable iff (!rstN)
    vbQ && !cfgHit |=> vbQ);
endmodule

// File: rtl/bsb_data.sv
module bsb_data
  import bsb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64,
  parameter int RA_W   = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bsbStrobe_t                 strobe,
  input  logic [$clog2(DEPTH)-1:0]   capIdx,
  input  logic [$clog2(DEPTH)-1:0]   swIdx,
  input  logic [ADDR_W-1:0]          brFrom,
  input  logic [ADDR_W-1:0]          brTo,
  input  logic [DATA_W-1:0]          regWrData,
  input  logic [RA_W-1:0]            regAddr,
  output logic [DATA_W-1:0]          entryRdData
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int EXT_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] fromQ [DEPTH];
  logic [ADDR_W-1:0] toQ   [DEPTH];
  logic [ADDR_W-1:0] rdRaw;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic capHere, swHere;
    assign capHere = strobe.capture && (capIdx == IDX_W'(i));
    assign swHere  = (swIdx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        fromQ[i] <= '0;
        toQ[i]   <= '0;
      end else if (capHere) begin
        fromQ[i] <= brFrom;
        toQ[i]   <= brTo;
      end else begin
        if (strobe.swWrFrom && swHere) fromQ[i] <= regWrData[ADDR_W-1:0];
        if (strobe.swWrTo && swHere)   toQ[i]   <= regWrData[ADDR_W-1:0];
      end
    end
  end

  always_comb begin
    rdRaw = '0;
    if (regAddr < RA_W'(2 * DEPTH))
      rdRaw = regAddr[0] ? toQ[regAddr[IDX_W:1]] : fromQ[regAddr[IDX_W:1]];
  end
  assign entryRdData = {{EXT_W{rdRaw[ADDR_W-1]}}, rdRaw};

  // R3: a capture lands in the entry named by the write index
  a_r3_capture_stores: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> toQ[$past(capIdx)] == $past(brTo)
                    && fromQ[$past(capIdx)] == $past(brFrom));
  // R11: software target write takes effect when no capture competes
  a_r11_sw_to: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swWrTo && !(strobe.capture && capIdx == swIdx)
    |=> toQ[$past(swIdx)] == $past(regWrData[ADDR_W-1:0]));
endmodule

// File: rtl/branch_sample_buf.sv
module branch_sample_buf
  import bsb_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ADDR_W  = 48,
  parameter int DATA_W  = 64,
  parameter int NUM_CNT = 8,
  localparam int RA_W   = $clog2(2 * DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               brValid,
  input  logic [ADDR_W-1:0]  brFrom,
  input  logic [ADDR_W-1:0]  brTo,
  input  logic [NUM_CNT-1:0] ovfIn,
  input  logic               regWrEn,
  input  logic [RA_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut
);
  localparam int IDX_W = $clog2(DEPTH);

  bsbStrobe_t        strobe;
  logic [IDX_W-1:0]  capIdx, swIdx;
  logic              cfgSel;
  logic [DATA_W-1:0] cfgRdData, entryRdData;

  bsb_ctrl #(.DEPTH(DEPTH), .NUM_CNT(NUM_CNT), .DATA_W(DATA_W), .RA_W(RA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .brValid(brValid), .ovfIn(ovfIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strobe(strobe), .capIdx(capIdx), .swIdx(swIdx), .cfgSel(cfgSel),
    .cfgRdData(cfgRdData), .irqOut(irqOut)
  );

  bsb_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RA_W(RA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .capIdx(capIdx), .swIdx(swIdx),
    .brFrom(brFrom), .brTo(brTo), .regWrData(regWrData), .regAddr(regAddr),
    .entryRdData(entryRdData)
  );

  assign regRdData = cfgSel ? cfgRdData : entryRdData;
endmodule

// File: tb/tb_branch_sample_buf.sv
module tb_branch_sample_buf;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        brValid = 1'b0;
  logic [47:0] brFrom = '0, brTo = '0;
  logic [7:0]  ovfIn = '0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        irqOut;

  int nChk = 0, nFail = 0;
  bit done = 0;
  localparam logic [5:0] CFG = 6'd32;

  always #5 clk = ~clk;

  branch_sample_buf dut (
    .clk(clk), .rstN(rstN), .brValid(brValid), .brFrom(brFrom), .brTo(brTo),
    .ovfIn(ovfIn), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic logic [63:0] fromVal(int i);
    if (i % 2 == 1) return 64'hFFFF_8000_0000_0000 | (64'(i) << 12);
    return 64'h0000_7000_0000_0000 + 64'(i) * 64'h40;
  endfunction
  function automatic logic [63:0] toVal(int i);
    if (i % 2 == 1) return 64'h0000_1000_0000_0000 + 64'(i) * 64'h8;
    return 64'hFFFF_C000_0000_0000 | (64'(i) << 4);
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, output logic [63:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic chkReg(string req, logic [5:0] a, logic [63:0] exp);
    logic [63:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wrReg(logic [5:0] a, logic [63:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic branch(logic [63:0] f, logic [63:0] t);
    brValid = 1'b1; brFrom = f[47:0]; brTo = t[47:0];
    @(negedge clk);
    brValid = 1'b0;
  endtask

  task automatic ovf(int n);
    ovfIn = 8'(1 << n);
    @(negedge clk);
    ovfIn = '0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chkReg("R1 cfg", CFG, 64'h18);
    chk("R1 irq", 64'(irqOut), 64'h0);
    for (int a = 0; a < 32; a++) chkReg("R1 entry", 6'(a), 64'h0);

    // R2 layout
    wrReg(CFG, 64'hFFFF_FFFF_FFFF_FFFF);
    chkReg("R2 all ones", CFG, 64'h070F_003C);
    wrReg(CFG, 64'h0);
    chkReg("R2 zero", CFG, 64'h18);

    // R4 disabled, select counter 2
    wrReg(CFG, 64'h0200_0000);
    branch(64'h0000_1111_2222_3333, 64'h0000_4444_5555_6666);
    chkReg("R4 cfg", CFG, 64'h0200_0018);
    chkReg("R4 to0", 6'd1, 64'h0);
    chkReg("R4 from0", 6'd0, 64'h0);

    // R9 selected overflow while disabled
    ovf(2);
    chk("R9 before", 64'(irqOut), 64'h0);
    @(negedge clk);
    chk("R9 pulse", 64'(irqOut), 64'h1);
    @(negedge clk);
    chk("R9 end", 64'(irqOut), 64'h0);
    // R8 foreign counter
    ovf(5);
    @(negedge clk); chk("R8 a", 64'(irqOut), 64'h0);
    @(negedge clk); chk("R8 b", 64'(irqOut), 64'h0);

    // R3/R6 full pass with held overflow
    wrReg(CFG, 64'h0200_0004);
    ovf(2);
    for (int i = 0; i < 15; i++) begin
      branch(fromVal(i), toVal(i));
      chk("R6 held", 64'(irqOut), 64'h0);
    end
    chkReg("R3 cfg idx15", CFG, 64'h020F_003C);
    branch(fromVal(15), toVal(15));
    chkReg("R5 cfg full", CFG, 64'h0200_0038);
    chk("R6 edge1", 64'(irqOut), 64'h0);
    @(negedge clk);
    chk("R6 pulse", 64'(irqOut), 64'h1);
    @(negedge clk);
    chk("R6 end", 64'(irqOut), 64'h0);
    for (int i = 0; i < 16; i++) begin
      chkReg("R3 R10 from", 6'(2 * i), fromVal(i));
      chkReg("R3 R10 to", 6'(2 * i + 1), toVal(i));
    end
    // R5 saturated: no more capture
    branch(64'h0000_0000_0000_0AAA, 64'h0000_0000_0000_0BBB);
    chkReg("R5 from0", 6'd0, fromVal(0));
    chkReg("R5 to0", 6'd1, toVal(0));
    chkReg("R5 cfg", CFG, 64'h0200_0038);

    // R7 software clear releases held overflow, R13 vb clear
    wrReg(CFG, 64'h0203_0004);
    ovf(2);
    branch(fromVal(1), toVal(1));
    chk("R7 held", 64'(irqOut), 64'h0);
    @(negedge clk);
    chk("R7 held2", 64'(irqOut), 64'h0);
    chkReg("R3 entry3", 6'd7, toVal(1));
    chkReg("R13 vb kept", CFG, 64'h0204_003C);
    wrReg(CFG, 64'h0204_0000);
    chk("R7 edge1", 64'(irqOut), 64'h0);
    @(negedge clk);
    chk("R7 pulse", 64'(irqOut), 64'h1);
    chkReg("R13 vb cleared", CFG, 64'h0204_0018);

    // R12 config write beats a branch in the same cycle
    wrReg(CFG, 64'h0205_0004);
    brValid = 1'b1; brFrom = 48'h1234; brTo = 48'h5678;
    regWrEn = 1'b1; regAddr = CFG; regWrData = 64'h0205_0000;
    @(negedge clk);
    brValid = 1'b0; regWrEn = 1'b0;
    chkReg("R12 cfg", CFG, 64'h0205_0018);
    chkReg("R12 entry5 to", 6'd11, toVal(5));
    chkReg("R12 entry5 from", 6'd10, fromVal(5));

    // R11 marker and positive software write
    wrReg(6'd15, 64'hFFFF_FFFF_FFFF_FFFE);
    chkReg("R11 marker", 6'd15, 64'hFFFF_FFFF_FFFF_FFFE);
    wrReg(6'd14, 64'h0000_1234_5678_9ABC);
    chkReg("R11 from", 6'd14, 64'h0000_1234_5678_9ABC);
    chkReg("R11 neighbour", 6'd13, toVal(6));

    finishRun();
  end
endmodule